// File: doc/BRIEF.md
# Lookup-Table RAM Cell

This block models the small random-access memory that a logic cell can form from the storage bits of its two 16-entry lookup tables. A mode input chooses the organisation (16 words of 1 bit, 16 words of 2 bits, or 32 words of 1 bit). A second input chooses whether a second, read-only port is present. A third chooses how a write shows up at the read side: committed on the clock edge, or transparent while write-enable is high.

The primary port has one address, a write-enable, write data and read data. Reads on both ports are asynchronous. When the second port is enabled, it reads any word through its own address while the primary port writes. Some combinations of organisation, port count and write style are not legal. For those the block raises an error output and accepts no writes.

Top module: `lutram_cell`

## Requirements
- R1: While rst_n is low and after its release, every stored bit is 0, and dout and dout2 read 0.
- R2: With org = 2'b00 (16x1), a write stores din[0] into word addr[3:0]. dout[0] returns that word, dout[1] is 0, and addr[4] has no effect.
- R3: With org = 2'b01 (16x2), a write stores both din bits into word addr[3:0], and dout returns both bits of that word.
- R4: With org = 2'b10 (32x1), addr[4] selects one of two independent 16-word halves. Together the two halves hold 32 separate 1-bit words, with din[0] written and dout[0] read.
- R5: In edge write style (level_wr = 0), reads are asynchronous. A read of the word being written returns the old value until the rising clock edge, and the new value right after it.
- R6: In level write style (level_wr = 1), while we is high dout shows din for the addressed word and follows changes of din within the cycle. The word keeps the din value present at the last rising edge with we high.
- R7: With dual_en = 1 in the legal mode (16x1, edge style), dout2[0] asynchronously returns word raddr2 at any address, including while the primary port writes. dout2 is 0 whenever the second port is not legally enabled.
- R8: mode_err is 1 exactly when org = 2'b11, or dual_en = 1 with org other than 2'b00, or dual_en = 1 with level_wr = 1.
- R9: While mode_err is 1, a write request changes no stored word.
- R10: The second port never writes. Only word addr is written, and raddr2 never selects the word that is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Active-low synchronous reset that clears storage |
| org | input | 2 | Organisation: 00 16x1, 01 16x2, 10 32x1, 11 reserved |
| dual_en | input | 1 | Enable second read-only port |
| level_wr | input | 1 | 1: level (transparent) write style, 0: edge style |
| we | input | 1 | Write enable, primary port |
| addr | input | 5 | Primary address; bit 4 used only in 32x1 |
| din | input | 2 | Write data; bit 1 used only in 16x2 |
| dout | output | 2 | Primary asynchronous read data |
| raddr2 | input | 4 | Second-port read address |
| dout2 | output | 1 | Second-port asynchronous read data |
| mode_err | output | 1 | Illegal mode combination |

## Verification
The block has two kinds of result timing. mode_err and both read ports are combinational: they are checked 1 ns after the inputs change, within the same low clock phase and before any edge. Stored data changes only on a rising edge. Edge-style writes are therefore checked twice: once before the edge, to see the old value, and again 1 ns after the edge, to see the new one. Level-style transparency is sampled while we is still high. Retention is sampled at the next falling edge, after we drops.

// File: rtl/lutram_pkg.sv
package lutram_pkg;

    typedef enum logic [1:0] {
        ORG_16X1 = 2'b00,
        ORG_16X2 = 2'b01,
        ORG_32X1 = 2'b10,
        ORG_RSVD = 2'b11
    } org_e;

    typedef struct packed {
        logic err;
        logic wr_ok;
        logic dual_ok;
        logic bypass;
    } mode_t;

endpackage

// File: rtl/lutram_mode_dec.sv
module lutram_mode_dec
    import lutram_pkg::*;
(
    input  logic [1:0] org,
    input  logic       dual_en,
    input  logic       level_wr,
    output mode_t      mode
);

    logic org_bad;
    logic dual_bad;

    always_comb begin
        org_bad  = (org_e'(org) == ORG_RSVD);
        dual_bad = dual_en && ((org_e'(org) != ORG_16X1) || level_wr);
        mode.err     = org_bad || dual_bad;
        mode.wr_ok   = !mode.err;
        mode.dual_ok = dual_en && !mode.err;
        mode.bypass  = level_wr && !mode.err;
    end

endmodule

// File: rtl/lutram_wr_ctl.sv
module lutram_wr_ctl
    import lutram_pkg::*;
#(
    parameter int LUT_AW = 4,
    parameter int NLUT   = 2
) (
    input  logic [1:0]      org,
    input  logic            we,
    input  logic            wr_ok,
    input  logic [LUT_AW:0] addr,
    input  logic [NLUT-1:0] din,
    output logic [NLUT-1:0] lut_we,
    output logic [NLUT-1:0] lut_wbit
);

    for (genvar i = 0; i < NLUT; i++) begin : g_sel
        logic picked;
        always_comb begin
            unique case (org_e'(org))
                ORG_16X1: picked = (i == 0);
                ORG_16X2: picked = 1'b1;
                ORG_32X1: picked = (addr[LUT_AW] == 1'(i));
                default:  picked = 1'b0;
            endcase
            lut_we[i]   = we && wr_ok && picked;
            lut_wbit[i] = (org_e'(org) == ORG_16X2) ? din[i] : din[0];
        end
    end

endmodule

// File: rtl/lutram_lut.sv
module lutram_lut #(
    parameter int AW  = 4,
    parameter int NRD = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic                   wr_bit,
    input  logic                   bypass_en,
    input  logic [NRD-1:0][AW-1:0] rd_addr,
    output logic [NRD-1:0]         rd_bit
);

    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DEPTH-1:0] bits;
    } lut_st_t;

    lut_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.bits[wr_addr] = wr_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (bypass_en && wr_en && (rd_addr[p] == wr_addr))
                rd_bit[p] = wr_bit;
            else
                rd_bit[p] = st_q.bits[rd_addr[p]];
        end
    end

    // R5
    edge_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.bits[$past(wr_addr)] == $past(wr_bit)));

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.bits));

endmodule

// File: rtl/lutram_cell.sv
module lutram_cell
    import lutram_pkg::*;
#(
    parameter int LUT_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        org,
    input  logic              dual_en,
    input  logic              level_wr,
    input  logic              we,
    input  logic [LUT_AW:0]   addr,
    input  logic [1:0]        din,
    output logic [1:0]        dout,
    input  logic [LUT_AW-1:0] raddr2,
    output logic              dout2,
    output logic              mode_err
);

    localparam int NLUT = 2;

    mode_t                         mode;
    logic [NLUT-1:0]               lut_we;
    logic [NLUT-1:0]               lut_wbit;
    logic [NLUT-1:0][1:0]          lut_rd;
    logic [1:0][LUT_AW-1:0]        rd_addrs;

    lutram_mode_dec u_dec (
        .org      (org),
        .dual_en  (dual_en),
        .level_wr (level_wr),
        .mode     (mode)
    );

    lutram_wr_ctl #(.LUT_AW(LUT_AW), .NLUT(NLUT)) u_wr (
        .org      (org),
        .we       (we),
        .wr_ok    (mode.wr_ok),
        .addr     (addr),
        .din      (din),
        .lut_we   (lut_we),
        .lut_wbit (lut_wbit)
    );

    assign rd_addrs[0] = addr[LUT_AW-1:0];
    assign rd_addrs[1] = raddr2;

    for (genvar i = 0; i < NLUT; i++) begin : g_lut
        lutram_lut #(.AW(LUT_AW), .NRD(2)) u_lut (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (lut_we[i]),
            .wr_addr   (addr[LUT_AW-1:0]),
            .wr_bit    (lut_wbit[i]),
            .bypass_en (mode.bypass),
            .rd_addr   (rd_addrs),
            .rd_bit    (lut_rd[i])
        );
    end

    always_comb begin
        unique case (org_e'(org))
            ORG_16X1: dout = {1'b0, lut_rd[0][0]};
            ORG_16X2: dout = {lut_rd[1][0], lut_rd[0][0]};
            ORG_32X1: dout = {1'b0, addr[LUT_AW] ? lut_rd[1][0] : lut_rd[0][0]};
            default:  dout = 2'b00;
        endcase
        dout2    = mode.dual_ok ? lut_rd[0][1] : 1'b0;
        mode_err = mode.err;
    end

    // R9
    no_write_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (lut_we == '0));

    // R8
    dual_level_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_en && level_wr) |-> mode_err);

    // R2
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (org == 2'b00) |-> (dout[1] == 1'b0));

    // R7
    port2_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dual_en |-> (dout2 == 1'b0));

endmodule

// File: tb/sim_lutram_cell.sv
module sim_lutram_cell;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] org = 2'b00;
    logic       dual_en = 1'b0;
    logic       level_wr = 1'b0;
    logic       we = 1'b0;
    logic [4:0] addr = '0;
    logic [1:0] din = '0;
    logic [3:0] raddr2 = '0;
    logic [1:0] dout;
    logic       dout2;
    logic       mode_err;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    lutram_cell u0 (
        .clk(clk), .rst_n(rst_n), .org(org), .dual_en(dual_en),
        .level_wr(level_wr), .we(we), .addr(addr), .din(din),
        .dout(dout), .raddr2(raddr2), .dout2(dout2), .mode_err(mode_err)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d t=%0t", req, got, exp, $time);
        end
    endtask

    task automatic setmode(input logic [1:0] o, input logic d, input logic l);
        @(negedge clk);
        org = o; dual_en = d; level_wr = l; we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; we = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [1:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; din = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [1:0] q);
        @(negedge clk);
        addr = a;
        #1 q = dout;
    endtask

    task automatic t_reset();
        logic [1:0] q;
        @(negedge clk);
        rst_n = 1'b0;
        setmode(2'b01, 1'b0, 1'b0);
        wr(5'd3, 2'b11);
        #1 chk("R1 dout during reset", dout, 0);
        do_reset();
        for (int a = 0; a < 16; a++) begin
            rd(5'(a), q);
            chk("R1 word after reset", q, 0);
        end
    endtask

    task automatic t_16x1();
        logic [1:0] q;
        do_reset();
        setmode(2'b00, 1'b0, 1'b0);
        wr(5'd6, 2'b11);
        wr(5'd9, 2'b00);
        rd(5'd6, q);  chk("R2 16x1 word 6", q, 1);
        rd(5'd22, q); chk("R2 16x1 addr[4] ignored", q, 1);
        rd(5'd9, q);  chk("R2 16x1 word 9", q, 0);
        wr(5'd25, 2'b01);
        rd(5'd9, q);  chk("R2 16x1 alias via addr[4]", q, 1);
    endtask

    task automatic t_16x2();
        logic [1:0] q;
        do_reset();
        setmode(2'b01, 1'b0, 1'b0);
        wr(5'd1, 2'b10);
        wr(5'd2, 2'b01);
        wr(5'd15, 2'b11);
        rd(5'd1, q);  chk("R3 16x2 word 1", q, 2);
        rd(5'd2, q);  chk("R3 16x2 word 2", q, 1);
        rd(5'd15, q); chk("R3 16x2 word 15", q, 3);
        rd(5'd0, q);  chk("R3 16x2 word 0", q, 0);
    endtask

    task automatic t_32x1();
        logic [1:0] q;
        do_reset();
        setmode(2'b10, 1'b0, 1'b0);
        wr(5'd4, 2'b01);
        wr(5'd20, 2'b00);
        wr(5'd31, 2'b01);
        rd(5'd4, q);  chk("R4 32x1 low half", q, 1);
        rd(5'd20, q); chk("R4 32x1 high half separate", q, 0);
        rd(5'd31, q); chk("R4 32x1 word 31", q, 1);
        rd(5'd15, q); chk("R4 32x1 word 15 untouched", q, 0);
    endtask

    task automatic t_edge();
        do_reset();
        setmode(2'b00, 1'b0, 1'b0);
        @(negedge clk);
        we = 1'b1; addr = 5'd3; din = 2'b01;
        #1 chk("R5 old value before edge", dout, 0);
        @(posedge clk);
        #1 chk("R5 new value after edge", dout, 1);
        @(negedge clk);
        din = 2'b00;
        #1 chk("R5 no transparency in edge style", dout, 1);
        @(posedge clk);
        #1 chk("R5 second edge stores 0", dout, 0);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic t_level();
        logic [1:0] q;
        do_reset();
        setmode(2'b10, 1'b0, 1'b1);
        #1 chk("R8 level single-port 32x1 legal", mode_err, 0);
        @(negedge clk);
        we = 1'b1; addr = 5'd21; din = 2'b01;
        #1 chk("R6 transparent follows din=1", dout, 1);
        din = 2'b00;
        #1 chk("R6 transparent follows din=0", dout, 0);
        din = 2'b01;
        @(negedge clk);
        we = 1'b0; din = 2'b00;
        #1 chk("R6 retains value at last edge", dout, 1);
        rd(5'd5, q);
        chk("R6 other half untouched", q, 0);
    endtask

    task automatic t_dual();
        do_reset();
        setmode(2'b00, 1'b1, 1'b0);
        #1 chk("R8 dual 16x1 edge legal", mode_err, 0);
        wr(5'd7, 2'b01);
        @(negedge clk);
        raddr2 = 4'd7; we = 1'b1; addr = 5'd9; din = 2'b01;
        #1 chk("R7 port2 reads during write", dout2, 1);
        raddr2 = 4'd9;
        #1 chk("R7 port2 old value before edge", dout2, 0);
        @(posedge clk);
        #1 chk("R7 port2 new value after edge", dout2, 1);
        @(negedge clk);
        we = 1'b1; addr = 5'd4; din = 2'b01; raddr2 = 4'd6;
        @(negedge clk);
        we = 1'b0;
        #1 chk("R10 raddr2 word not written", dout2, 0);
        raddr2 = 4'd4;
        #1 chk("R10 addr word written", dout2, 1);
        setmode(2'b00, 1'b0, 1'b0);
        #1 chk("R7 port2 zero when disabled", dout2, 0);
    endtask

    task automatic t_modes();
        setmode(2'b11, 1'b0, 1'b0); #1 chk("R8 reserved org", mode_err, 1);
        setmode(2'b01, 1'b1, 1'b0); #1 chk("R8 dual 16x2", mode_err, 1);
        setmode(2'b10, 1'b1, 1'b0); #1 chk("R8 dual 32x1", mode_err, 1);
        setmode(2'b00, 1'b1, 1'b1); #1 chk("R8 dual level", mode_err, 1);
        setmode(2'b01, 1'b0, 1'b1); #1 chk("R8 level 16x2 legal", mode_err, 0);
        setmode(2'b01, 1'b1, 1'b0); #1 chk("R7 dout2 zero on err", dout2, 0);
    endtask

    task automatic t_err_block();
        logic [1:0] q;
        do_reset();
        setmode(2'b01, 1'b1, 1'b0);
        wr(5'd5, 2'b11);
        setmode(2'b00, 1'b1, 1'b1);
        wr(5'd6, 2'b01);
        setmode(2'b11, 1'b0, 1'b0);
        wr(5'd7, 2'b11);
        setmode(2'b01, 1'b0, 1'b0);
        rd(5'd5, q); chk("R9 no write dual 16x2", q, 0);
        rd(5'd6, q); chk("R9 no write dual level", q, 0);
        rd(5'd7, q); chk("R9 no write reserved org", q, 0);
    endtask

    initial begin
        t_reset();
        t_16x1();
        t_16x2();
        t_32x1();
        t_edge();
        t_level();
        t_dual();
        t_modes();
        t_err_block();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule